// File: doc/BRIEF.md
# Radix-2 Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits over several clock cycles and returns the full signed product of `2*WIDTH` bits. A pulse on `start_i` while the block is idle captures both operands. The block then runs one recoding step per clock for `WIDTH` clocks. Each step looks at the lowest multiplier bit and the bit shifted out just before it. On a transition into a run of ones it subtracts the multiplicand from the accumulator. On a transition out of such a run it adds the multiplicand. Inside a run, or inside a run of zeros, it leaves the accumulator unchanged. After every step the accumulator, the multiplier register and the extra low bit all move one place right as a single arithmetic shift, and the sign of the accumulator is copied into the vacated top bit.

The adder is one complement-and-add stage. It subtracts by inverting the multiplicand and forcing a carry-in of one, and it drops the carry-out. The accumulator has one guard bit above the operand width, so the most negative multiplicand still yields the exact product. The result reads out as the accumulator's low part joined to the multiplier register. It stays on the output until the next operation is accepted.

Top module: `booth_mul`

## Requirements
- R1: During and after reset, until the first start, `busy_o` and `done_o` are 0 and `product_o` is all zeros.
- R2: A `start_i` sampled high at a clock edge while `busy_o` is 0 makes `busy_o` 1 for exactly `WIDTH` cycles, beginning right after that edge.
- R3: `done_o` goes high for one cycle in the cycle in which `busy_o` returns to 0, and at no other time.
- R4: When `done_o` is high, `product_o` equals the signed product of the captured operands, written as a `2*WIDTH`-bit two's-complement value. It keeps that value until the next start is accepted.
- R5: While `busy_o` is 1, `start_i` and any change of the operand inputs have no effect on the result or on the timing.
- R6: Each step subtracts the multiplicand when the bit pair (multiplier LSB, appended bit) is (1,0), adds it when the pair is (0,1), and leaves the accumulator unchanged when the two bits are equal. The product is correct for negative as well as positive multipliers.
- R7: The most negative operand value (-2^(WIDTH-1)) gives the exact product in either operand position, including the square of that value, which is +2^(2*WIDTH-2).
- R8: A zero operand in either position gives a product of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a multiplication; taken only while idle |
| mcand_i | input | WIDTH | Signed multiplicand |
| mplier_i | input | WIDTH | Signed multiplier |
| busy_o | output | 1 | Recoding steps are in progress |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| product_o | output | 2*WIDTH | Signed product |

## Verification
The assertions assume that `start_i` is driven to a known level at every clock after reset and that it may arrive at any time, including while a multiplication is running. They also assume the operands only need to be valid in the cycle in which a start is accepted. The stimulus changes all inputs only on falling edges. It scrambles the operands as soon as a start has been taken, and in part of the runs it fires extra starts with other operands in the middle of a run. This exercises the ignore rule without ever leaving the input assumptions. Every signed operand pair is applied, with idle gaps between operations, so the hold rule on the product is also covered.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } booth_state_e;

    typedef enum logic [1:0] {
        OP_KEEP = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic      q_lsb_i,
    input  logic      q_ext_i,
    output booth_op_e op_o
);
    always_comb begin
        unique case ({q_lsb_i, q_ext_i})
            2'b10:   op_o = OP_SUB;
            2'b01:   op_o = OP_ADD;
            default: op_o = OP_KEEP;
        endcase
    end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int unsigned DW = 6
) (
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] operand_i,
    input  booth_op_e     op_i,
    output logic [DW-1:0] res_o
);
    logic [DW-1:0] addend;
    logic          cin;
    logic [DW:0]   full;

    always_comb begin
        addend = '0;
        cin    = 1'b0;
        unique case (op_i)
            OP_ADD: addend = operand_i;
            OP_SUB: begin
                addend = ~operand_i;
                cin    = 1'b1;
            end
            default: addend = '0;
        endcase
        full  = {1'b0, acc_i} + {1'b0, addend} + {{DW{1'b0}}, cin};
        res_o = full[DW-1:0];
    end
endmodule

// File: rtl/booth_ashr.sv
module booth_ashr #(
    parameter int unsigned SW = 12
) (
    input  logic [SW-1:0] vec_i,
    output logic [SW-1:0] vec_o
);
    assign vec_o = {vec_i[SW-1], vec_i[SW-1:1]};
endmodule

// File: rtl/booth_mul.sv
module booth_mul
    import booth_pkg::*;
#(
    parameter int unsigned WIDTH = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [WIDTH-1:0]   mcand_i,
    input  logic [WIDTH-1:0]   mplier_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [2*WIDTH-1:0] product_o
);
    localparam int unsigned AW = WIDTH + 1;
    localparam int unsigned SW = AW + WIDTH + 1;
    localparam int unsigned CW = $clog2(WIDTH + 1);

    typedef struct packed {
        booth_state_e   st;
        logic [AW-1:0]  br;
        logic [AW-1:0]  ac;
        logic [WIDTH-1:0] qr;
        logic           qx;
        logic [CW-1:0]  cnt;
        logic           done;
    } regs_t;

    regs_t q, d;

    booth_op_e     op_w;
    logic [AW-1:0] sum_w;
    logic [SW-1:0] shin_w;
    logic [SW-1:0] shout_w;

    logic [CW-1:0] cnt_w;
    logic [AW-1:0] ac_w;
    logic          pair_eq_w;

    booth_recode recode_i (
        .q_lsb_i (q.qr[0]),
        .q_ext_i (q.qx),
        .op_o    (op_w)
    );

    booth_addsub #(.DW(AW)) addsub_i (
        .acc_i     (q.ac),
        .operand_i (q.br),
        .op_i      (op_w),
        .res_o     (sum_w)
    );

    assign shin_w = {sum_w, q.qr, q.qx};

    booth_ashr #(.SW(SW)) ashr_i (
        .vec_i (shin_w),
        .vec_o (shout_w)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st  = ST_RUN;
                    d.br  = {mcand_i[WIDTH-1], mcand_i};
                    d.ac  = '0;
                    d.qr  = mplier_i;
                    d.qx  = 1'b0;
                    d.cnt = CW'(WIDTH);
                end
            end
            ST_RUN: begin
                d.ac  = shout_w[SW-1 -: AW];
                d.qr  = shout_w[WIDTH:1];
                d.qx  = shout_w[0];
                d.cnt = q.cnt - CW'(1);
                if (q.cnt == CW'(1)) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, br: '0, ac: '0, qr: '0, qx: 1'b0, cnt: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy_o    = (q.st == ST_RUN);
    assign done_o    = q.done;
    assign product_o = {q.ac[WIDTH-1:0], q.qr};

    assign cnt_w     = q.cnt;
    assign ac_w      = q.ac;
    assign pair_eq_w = (q.qr[0] == q.qx);
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
    parameter int unsigned WIDTH = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               busy_o,
    input logic               done_o,
    input logic [2*WIDTH-1:0] product_o,
    input logic [$clog2(WIDTH+1)-1:0] cnt,
    input logic [WIDTH:0]     ac,
    input logic               pair_eq
);
    // R2
    start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R2
    cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (cnt != '0));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R4
    product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(product_o));

    // R6
    keep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && pair_eq) |=> (ac == {$past(ac[WIDTH]), $past(ac[WIDTH:1])}));
endmodule

bind booth_mul booth_mul_chk #(.WIDTH(WIDTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o),
    .cnt       (cnt_w),
    .ac        (ac_w),
    .pair_eq   (pair_eq_w)
);

// File: tb/booth_mul_tb_top.sv
module booth_mul_tb_top;
    localparam int W  = 5;
    localparam int PW = 2 * W;
    localparam int LO = -(1 << (W - 1));
    localparam int HI = (1 << (W - 1)) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [W-1:0]  mcand_i = '0;
    logic [W-1:0]  mplier_i = '0;
    logic          busy_o;
    logic          done_o;
    logic [PW-1:0] product_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    booth_mul #(.WIDTH(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .mcand_i   (mcand_i),
        .mplier_i  (mplier_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .product_o (product_o)
    );

    // behavioural reference, advanced at every rising edge
    int            rem = 0;
    logic          exp_busy = 1'b0;
    logic          exp_done = 1'b0;
    logic [PW-1:0] exp_prod = '0;
    logic [PW-1:0] pend = '0;
    string         cur_tag = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            rem = 0; exp_busy = 1'b0; exp_done = 1'b0; exp_prod = '0;
        end else begin
            exp_done = 1'b0;
            if (rem > 0) begin
                rem = rem - 1;
                if (rem == 0) begin
                    exp_busy = 1'b0;
                    exp_done = 1'b1;
                    exp_prod = pend;
                end
            end else if (start_i) begin
                rem      = W;
                exp_busy = 1'b1;
                pend     = PW'(int'($signed(mcand_i)) * int'($signed(mplier_i)));
            end
        end
    end

    task automatic chk(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2 busy", PW'(busy_o), PW'(exp_busy));
            chk("R3 done", PW'(done_o), PW'(exp_done));
            if (!exp_busy) chk(cur_tag, product_o, exp_prod);
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : drive
        repeat (3) @(negedge clk);
        // R1 values while reset is held
        chk("R1 busy", PW'(busy_o), '0);
        chk("R1 done", PW'(done_o), '0);
        chk("R1 product", product_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 product after release", product_o, '0);
        for (int ia = LO; ia <= HI; ia++) begin
            for (int ib = LO; ib <= HI; ib++) begin
                bit hit;
                hit = (((ia + ib) % 7) == 0);
                if (ia == LO || ib == LO)      cur_tag = "R7 product";
                else if (ia == 0 || ib == 0)   cur_tag = "R8 product";
                else if (hit)                  cur_tag = "R5 product";
                else if (ib < 0)               cur_tag = "R6 product";
                else                           cur_tag = "R4 product";
                mcand_i  = W'(ia);
                mplier_i = W'(ib);
                start_i  = 1'b1;
                @(negedge clk);
                start_i  = 1'b0;
                mcand_i  = ~mcand_i;
                mplier_i = mplier_i ^ W'(5);
                if (hit) begin
                    // R5: start pulse mid-run with other operands
                    @(negedge clk);
                    start_i  = 1'b1;
                    mcand_i  = W'(3);
                    mplier_i = W'(-3);
                    @(negedge clk);
                    start_i  = 1'b0;
                end
                while (!done_o) @(negedge clk);
                @(negedge clk);
            end
        end
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule